// File: doc/BRIEF.md
# UV-PROM Programming Sequencer

This block writes a stream of address/byte pairs into an 8K x 8 ultraviolet-erasable PROM and checks each byte after it has been written. A host opens a session with a start pulse. The sequencer then takes pairs over a valid/ready handshake. For each pair it first reads the byte already stored at that address. Because an erased cell reads 1 and programming can only clear bits, a target that needs any 0 turned back into 1 cannot be written. Such a location is flagged and skipped, and no pulse is issued for it.

For a location that can be written, the sequencer drives the address and the byte onto the device bus. After a setup count it issues one active-low program strobe of a fixed, clamped width. It holds the byte for a hold count, then releases the bus and reads the byte back in verify mode. Chip enable stays low and the programming-voltage enable stays high for the whole session. A verify mismatch ends the session at once: the sequencer drops chip enable and the voltage enable and latches the failing address, the expected byte and the byte read back. A pair marked last closes the session successfully. Pairs may arrive in any address order. The external high-voltage generator is driven only through the enable output.

Top module: `prom_prog_seq`

## Requirements
- R1: After reset and whenever no session is open: prom_ce_n=1, prom_oe_n=1, prom_pgm_n=1, vpp_en=0, prom_dq_oe=0, in_ready=0, busy=0.
- R2: From the start pulse until the session closes, prom_ce_n=0, vpp_en=1 and busy=1. in_ready is high only while the sequencer waits for the next pair, and a pair is taken on a clock edge where in_valid and in_ready are both 1.
- R3: Before any pulse, the stored byte is read with prom_oe_n=0, prom_pgm_n=1 and prom_dq_oe=0. If any bit is 0 in the stored byte and 1 in the target, no pulse is issued, the stored byte is left unchanged, loc_skip is high for exactly one cycle and the next pair is taken. A target whose 1-bits are a subset of the stored byte is programmed.
- R4: With prom_oe_n=1, the byte is driven (prom_dq_oe=1) for exactly SETUP_CYC cycles before prom_pgm_n falls. prom_addr and prom_dq_o do not change while prom_pgm_n is low.
- R5: Each programmed location gets exactly one low pulse on prom_pgm_n. The pulse lasts min(PULSE_CYC, LIMIT_MS*CYC_PER_MS) cycles.
- R6: After prom_pgm_n rises, the byte stays driven for exactly HOLD_CYC cycles before prom_dq_oe drops.
- R7: In verify mode (prom_oe_n=0, prom_pgm_n=1, prom_dq_oe=0), a byte read back that equals the target moves the sequencer to the next pair. A pair with in_last=1 that verifies or is skipped closes the session with done=1 and fail=0.
- R8: On a verify mismatch the session closes with fail=1 and done=0. fail_addr, fail_exp and fail_act hold the address, the target byte and the byte read back, vpp_en=0 and prom_ce_n=1, and no further pair is accepted.
- R9: prom_pgm_n is low only while prom_ce_n=0, vpp_en=1, prom_dq_oe=1 and prom_oe_n=1.
- R10: prom_dq_oe=1 and prom_oe_n=0 never occur together.
- R11: A start pulse while a session is open has no effect. A start pulse with no session open clears done and fail and opens a new session.
- R12: Locations are programmed correctly whatever the order of their addresses, including the lowest and highest address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Opens a programming session |
| in_valid | input | 1 | Host pair valid |
| in_ready | output | 1 | Sequencer ready to take a pair |
| in_addr | input | ADDR_W | Target address |
| in_data | input | DATA_W | Target byte |
| in_last | input | 1 | Marks the final pair of the session |
| prom_addr | output | ADDR_W | Device address |
| prom_dq_o | output | DATA_W | Byte driven to the device |
| prom_dq_i | input | DATA_W | Byte read from the device |
| prom_dq_oe | output | 1 | 1 while the sequencer drives the data bus |
| prom_ce_n | output | 1 | Chip enable, active low |
| prom_oe_n | output | 1 | Output enable, active low |
| prom_pgm_n | output | 1 | Program strobe, active low |
| vpp_en | output | 1 | Enable for the programming-voltage rail |
| busy | output | 1 | Session open |
| done | output | 1 | Last session closed successfully |
| fail | output | 1 | Last session closed on a verify mismatch |
| loc_skip | output | 1 | One-cycle flag: current location cannot be programmed |
| fail_addr | output | ADDR_W | Address of the failing location |
| fail_exp | output | DATA_W | Byte that was expected there |
| fail_act | output | DATA_W | Byte that was read back |

## Verification
A stuck or wrong sequencer state appears at the device pins within one cycle. The control combination on prom_ce_n, prom_oe_n, prom_pgm_n and prom_dq_oe is decoded straight from the state, so a bad state shows up at once as a forbidden pairing, such as the strobe low while the bus is released, or as a drive/read overlap. A timer that loads the wrong count shows up as a setup, pulse or hold run of the wrong length, measured at the first strobe edge after the fault. A wrong compatibility or compare decision shows up in the device contents, in the skip flag and in the done/fail outcome of the same location before the next pair is taken.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_PRERD  = 3'd2,
    ST_SETUP  = 3'd3,
    ST_PULSE  = 3'd4,
    ST_HOLD   = 3'd5,
    ST_VERIFY = 3'd6
  } seq_state_e;

endpackage

// File: rtl/prog_rst_sync.sv
module prog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/prog_bitcheck.sv
module prog_bitcheck #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] cur_byte,
  input  logic [DATA_W-1:0] tgt_byte,
  output logic              can_prog,
  output logic              same
);

  logic [DATA_W-1:0] need_set;

  always_comb begin
    need_set = (~cur_byte) & tgt_byte;
    can_prog = (need_set == '0);
    same     = (cur_byte == tgt_byte);
  end

endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
  import prom_prog_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int CYC_PER_MS = 125000,
  parameter int PULSE_CYC  = 6250000,
  parameter int LIMIT_MS   = 55,
  parameter int SETUP_CYC  = 4,
  parameter int HOLD_CYC   = 4,
  parameter int RD_CYC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic [ADDR_W-1:0] prom_addr,
  output logic [DATA_W-1:0] prom_dq_o,
  input  logic [DATA_W-1:0] prom_dq_i,
  output logic              prom_dq_oe,
  output logic              prom_ce_n,
  output logic              prom_oe_n,
  output logic              prom_pgm_n,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              loc_skip,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);

  localparam int PULSE_MAX = LIMIT_MS * CYC_PER_MS;
  localparam int PULSE_EFF = (PULSE_CYC > PULSE_MAX) ? PULSE_MAX : PULSE_CYC;
  localparam int T_A       = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int T_B       = (T_A > RD_CYC) ? T_A : RD_CYC;
  localparam int T_MAX     = (T_B > PULSE_EFF) ? T_B : PULSE_EFF;
  localparam int CNT_W     = $clog2(T_MAX + 1);

  logic rst_s;

  prog_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              last_q;
  logic              done_q, fail_q, skip_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic [DATA_W-1:0] fail_exp_q, fail_act_q;

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  logic              can_prog, rd_same;

  logic              take_pair;
  logic              skip_d;
  logic              done_set, fail_set, open_sess;

  prog_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  prog_bitcheck #(.DATA_W(DATA_W)) bitcheck_i (
    .cur_byte (prom_dq_i),
    .tgt_byte (data_q),
    .can_prog (can_prog),
    .same     (rd_same)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    skip_d    = 1'b0;
    done_set  = 1'b0;
    fail_set  = 1'b0;
    open_sess = 1'b0;
    take_pair = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_FETCH;
          open_sess = 1'b1;
        end
      end
      ST_FETCH: begin
        if (in_valid) begin
          state_d   = ST_PRERD;
          take_pair = 1'b1;
        end
      end
      ST_PRERD: begin
        if (tmr_exp) begin
          if (can_prog) begin
            state_d = ST_SETUP;
          end else begin
            skip_d = 1'b1;
            if (last_q) begin
              state_d  = ST_IDLE;
              done_set = 1'b1;
            end else begin
              state_d = ST_FETCH;
            end
          end
        end
      end
      ST_SETUP: if (tmr_exp) state_d = ST_PULSE;
      ST_PULSE: if (tmr_exp) state_d = ST_HOLD;
      ST_HOLD:  if (tmr_exp) state_d = ST_VERIFY;
      ST_VERIFY: begin
        if (tmr_exp) begin
          if (!rd_same) begin
            state_d  = ST_IDLE;
            fail_set = 1'b1;
          end else if (last_q) begin
            state_d  = ST_IDLE;
            done_set = 1'b1;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // timer reload on every state change
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_PRERD, ST_VERIFY: tmr_val = CNT_W'(RD_CYC - 1);
      ST_SETUP:            tmr_val = CNT_W'(SETUP_CYC - 1);
      ST_PULSE:            tmr_val = CNT_W'(PULSE_EFF - 1);
      ST_HOLD:             tmr_val = CNT_W'(HOLD_CYC - 1);
      default:             tmr_val = '0;
    endcase
  end

  // state and status registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      skip_q  <= skip_d;
      if (open_sess || done_set) begin
        done_q <= done_set;
      end
      if (open_sess || fail_set) begin
        fail_q <= fail_set;
      end
    end
  end

  // pair capture
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      addr_q <= '0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (take_pair) begin
      addr_q <= in_addr;
      data_q <= in_data;
      last_q <= in_last;
    end
  end

  // failure capture
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fail_addr_q <= '0;
      fail_exp_q  <= '0;
      fail_act_q  <= '0;
    end else if (fail_set) begin
      fail_addr_q <= addr_q;
      fail_exp_q  <= data_q;
      fail_act_q  <= prom_dq_i;
    end
  end

  // pin decode from state
  always_comb begin
    busy       = (state_q != ST_IDLE);
    in_ready   = (state_q == ST_FETCH);
    prom_ce_n  = !busy;
    vpp_en     = busy;
    prom_oe_n  = !((state_q == ST_PRERD) || (state_q == ST_VERIFY));
    prom_dq_oe = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
    prom_pgm_n = (state_q != ST_PULSE);
  end

  assign prom_addr = addr_q;
  assign prom_dq_o = data_q;
  assign done      = done_q;
  assign fail      = fail_q;
  assign loc_skip  = skip_q;
  assign fail_addr = fail_addr_q;
  assign fail_exp  = fail_exp_q;
  assign fail_act  = fail_act_q;

endmodule

// File: rtl/prom_prog_seq_chk.sv
module prom_prog_seq_chk #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PULSE_LIM = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              in_ready,
  input logic              fail,
  input logic [ADDR_W-1:0] prom_addr,
  input logic [DATA_W-1:0] prom_dq_o,
  input logic              prom_dq_oe,
  input logic              prom_ce_n,
  input logic              prom_oe_n,
  input logic              prom_pgm_n,
  input logic              vpp_en
);

  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= 0;
    end else if (!prom_pgm_n) begin
      low_cnt <= low_cnt + 1;
    end else begin
      low_cnt <= 0;
    end
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prom_ce_n && !vpp_en && prom_pgm_n && !prom_dq_oe));

  // R2
  ready_in_sess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !prom_ce_n && vpp_en));

  // R4
  pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prom_pgm_n && $past(!prom_pgm_n)) |-> ($stable(prom_addr) && $stable(prom_dq_o)));

  // R5
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prom_pgm_n |-> (low_cnt < PULSE_LIM));

  // R8
  fail_vpp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !busy) |-> (!vpp_en && prom_ce_n));

  // R9
  pgm_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prom_pgm_n |-> (!prom_ce_n && vpp_en && prom_dq_oe && prom_oe_n));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prom_dq_oe && !prom_oe_n));

endmodule

bind prom_prog_seq prom_prog_seq_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PULSE_LIM (PULSE_EFF)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_s),
  .busy       (busy),
  .in_ready   (in_ready),
  .fail       (fail),
  .prom_addr  (prom_addr),
  .prom_dq_o  (prom_dq_o),
  .prom_dq_oe (prom_dq_oe),
  .prom_ce_n  (prom_ce_n),
  .prom_oe_n  (prom_oe_n),
  .prom_pgm_n (prom_pgm_n),
  .vpp_en     (vpp_en)
);

// File: tb/prom_prog_seq_tb_top.sv
`timescale 1ns/1ps
module prom_prog_seq_tb_top;

  localparam int AW    = 13;
  localparam int DW    = 8;
  localparam int CPM   = 4;
  localparam int PCYC  = 500;
  localparam int SETUP = 3;
  localparam int HOLD  = 2;
  localparam int RDC   = 2;
  localparam int EXP_W = (PCYC > 55 * CPM) ? 55 * CPM : PCYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready, prom_dq_oe, prom_ce_n, prom_oe_n, prom_pgm_n, vpp_en;
  logic busy, done, fail, loc_skip;
  logic [AW-1:0] prom_addr, fail_addr;
  logic [DW-1:0] prom_dq_o, prom_dq_i, fail_exp, fail_act;

  always #4 clk = ~clk;

  prom_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CYC_PER_MS(CPM), .PULSE_CYC(PCYC),
    .LIMIT_MS(55), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .RD_CYC(RDC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .in_last(in_last), .prom_addr(prom_addr), .prom_dq_o(prom_dq_o),
    .prom_dq_i(prom_dq_i), .prom_dq_oe(prom_dq_oe), .prom_ce_n(prom_ce_n),
    .prom_oe_n(prom_oe_n), .prom_pgm_n(prom_pgm_n), .vpp_en(vpp_en),
    .busy(busy), .done(done), .fail(fail), .loc_skip(loc_skip),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // device model
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] stuck_addr = '0;
  logic [DW-1:0] stuck_mask = '0;

  assign prom_dq_i = (!prom_ce_n && !prom_oe_n && prom_pgm_n) ? mem[prom_addr] : '0;

  int total = 0;
  int bad = 0;

  // monitors, sampled on the falling edge
  int pulses = 0, skips = 0, pw_run = 0, last_pw = 0;
  int drv_run = 0, last_setup = 0, last_hold = 0;
  int unstable = 0, unsafe = 0, clash = 0;
  logic pgm_prev = 1'b1;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  always @(negedge clk) begin
    if (loc_skip) skips++;
    if (!prom_pgm_n && (prom_ce_n || !vpp_en || !prom_dq_oe || !prom_oe_n)) unsafe++;
    if (prom_dq_oe && !prom_oe_n) clash++;
    if (!prom_pgm_n) begin
      if (pgm_prev) begin
        last_setup = drv_run;
        p_addr = prom_addr;
        p_data = prom_dq_o;
        pw_run = 0;
      end else if (prom_addr != p_addr || prom_dq_o != p_data) begin
        unstable++;
      end
      pw_run++;
      drv_run = 0;
    end else begin
      if (!pgm_prev) begin
        last_pw = pw_run;
        pulses++;
        if (p_addr == stuck_addr)
          mem[p_addr] = mem[p_addr] & (p_data | stuck_mask);
        else
          mem[p_addr] = mem[p_addr] & p_data;
      end
      if (prom_dq_oe) drv_run++;
      else begin
        if (drv_run != 0) last_hold = drv_run;
        drv_run = 0;
      end
    end
    pgm_prev = prom_pgm_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_pair(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(prom_ce_n && prom_oe_n && prom_pgm_n, "R1 ctrl pins idle", {prom_ce_n, prom_oe_n, prom_pgm_n}, 3'b111);
    chk(!vpp_en && !prom_dq_oe, "R1 vpp/bus idle", {vpp_en, prom_dq_oe}, 0);
    chk(!in_ready && !busy, "R1 handshake idle", {in_ready, busy}, 0);
  endtask

  task automatic t_basic();
    int p0;
    p0 = pulses;
    pulse_start();
    chk(busy && !prom_ce_n && vpp_en, "R2 session open", {busy, prom_ce_n, vpp_en}, 3'b101);
    send_pair(13'h1FFF, 8'hA5, 1'b0);
    send_pair(13'h0000, 8'h3C, 1'b0);
    send_pair(13'h0840, 8'h00, 1'b1);
    wait_idle();
    chk(mem[13'h1FFF] == 8'hA5, "R12 high addr", mem[13'h1FFF], 8'hA5);
    chk(mem[13'h0000] == 8'h3C, "R12 low addr", mem[13'h0000], 8'h3C);
    chk(mem[13'h0840] == 8'h00, "R12 mid addr", mem[13'h0840], 8'h00);
    chk(pulses - p0 == 3, "R5 one pulse per location", pulses - p0, 3);
    chk(last_pw == EXP_W, "R5 clamped pulse width", last_pw, EXP_W);
    chk(last_setup == SETUP, "R4 setup cycles", last_setup, SETUP);
    chk(last_hold == HOLD, "R6 hold cycles", last_hold, HOLD);
    chk(unstable == 0, "R4 addr/data stable in pulse", unstable, 0);
    chk(done && !fail, "R7 done after last", {done, fail}, 2'b10);
    chk(prom_ce_n && !vpp_en, "R2 session closed", {prom_ce_n, vpp_en}, 2'b10);
  endtask

  task automatic t_skip();
    int p0, s0;
    mem[13'h0100] = 8'h0F;
    mem[13'h0102] = 8'h0F;
    p0 = pulses; s0 = skips;
    pulse_start();
    chk(!done, "R11 start clears done", done, 0);
    send_pair(13'h0100, 8'hF0, 1'b0);
    send_pair(13'h0102, 8'h05, 1'b0);
    send_pair(13'h0101, 8'h55, 1'b1);
    wait_idle();
    chk(mem[13'h0100] == 8'h0F, "R3 incompatible left alone", mem[13'h0100], 8'h0F);
    chk(skips - s0 == 1, "R3 one skip flag", skips - s0, 1);
    chk(mem[13'h0102] == 8'h05, "R3 subset programmed", mem[13'h0102], 8'h05);
    chk(mem[13'h0101] == 8'h55, "R7 later pair programmed", mem[13'h0101], 8'h55);
    chk(pulses - p0 == 2, "R3 no pulse on skip", pulses - p0, 2);
    chk(done && !fail, "R7 done", {done, fail}, 2'b10);
  endtask

  task automatic t_start_busy();
    int p0;
    p0 = pulses;
    pulse_start();
    send_pair(13'h0200, 8'h81, 1'b0);
    pulse_start();
    chk(busy && !done, "R11 start while busy ignored", {busy, done}, 2'b10);
    send_pair(13'h0201, 8'h7E, 1'b1);
    wait_idle();
    chk(pulses - p0 == 2 && mem[13'h0201] == 8'h7E, "R11 session unaffected", pulses - p0, 2);
    chk(done, "R11 done", done, 1);
  endtask

  task automatic t_fail();
    bit taken;
    stuck_addr = 13'h0300;
    stuck_mask = 8'h01;
    pulse_start();
    send_pair(13'h0300, 8'hFE, 1'b0);
    wait_idle();
    chk(fail && !done, "R8 fail flag", {fail, done}, 2'b10);
    chk(fail_addr == 13'h0300, "R8 fail addr", fail_addr, 13'h0300);
    chk(fail_exp == 8'hFE, "R8 expected byte", fail_exp, 8'hFE);
    chk(fail_act == 8'hFF, "R8 actual byte", fail_act, 8'hFF);
    chk(!vpp_en && prom_ce_n, "R8 vpp off", {vpp_en, prom_ce_n}, 2'b01);
    taken = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 13'h0301; in_data = 8'h00; in_last = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (in_ready || busy) taken = 1'b1;
    end
    in_valid = 1'b0;
    chk(!taken && mem[13'h0301] == 8'hFF, "R8 no pair after fail", taken, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_skip();
    t_start_busy();
    t_fail();
    chk(unsafe == 0, "R9 strobe only when safe", unsafe, 0);
    chk(clash == 0, "R10 no bus clash", clash, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule